// File: doc/BRIEF.md
# Serial Flash Slave Front End with Pause

This block is the device-side serial front end of a flash memory. It watches the chip select, serial clock, serial data input and a pause pin, all of which are asynchronous to the system clock. It turns the incoming bit stream into bytes, most significant bit first, and raises a one-cycle strobe with each finished byte. In the same way it takes bytes from the core and shifts them out on a serial data output. That output has its own enable, so it can be tri-stated.

Both clock polarities are accepted: the clock may idle low or idle high while chip select changes. Incoming bits are taken on rising clock edges. Outgoing bits change on falling edges. A new outgoing byte is loaded at the falling edge that begins each byte slot.

The pause pin freezes a transfer part-way through a byte, and the transfer later resumes from the exact bit where it stopped. Entry to and exit from the pause are timed by the clock level. When a configuration bit selects four-lane use, the pause function is switched off and the pin is passed through as data lane 3.

Top module: `sflash_front`

## Requirements
- R1: In both clock polarities (idle low and idle high), each rising serial clock edge shifts one input bit in, most significant bit first. After the eighth bit, `rx_byte` holds the byte and `rx_valid` is high for exactly one system clock.
- R2: `sdo` changes only on falling serial clock edges. At a falling edge where no bit of the current byte has yet been sampled, `tx_byte` is loaded, its bit 7 appears on `sdo`, and `tx_taken` pulses for one cycle. Each later falling edge presents the next lower bit.
- R3: `sdo_oe` is 1 only while chip select is low, `tx_en` is 1 and no pause is active. Otherwise it is 0.
- R4: If the pause pin goes low while chip select is low and the serial clock is low, the pause starts without waiting for any clock edge.
- R5: If the pause pin goes low while the serial clock is high, the pause starts only at the next falling clock edge.
- R6: The pause ends as soon as the pause pin is high while the clock is low. If the pin rises while the clock is high, the pause ends only at the next falling edge.
- R7: During a pause, `sdo_oe` is 0 and both clock edges and `sdi` are ignored. The bit position and both shift registers are kept, so the byte completes correctly after the pause.
- R8: With `quad_en` = 1, the pause pin never starts a pause, and `lane3` follows the pin level. With `quad_en` = 0, `lane3` is 0. `quad_en` resets to 0 in the surrounding logic.
- R9: Chip select going high, including during a pause, ends the pause and clears the bit position. A partial byte is then discarded, and the next selection starts a fresh byte.
- R10: After reset, `rx_valid`, `tx_taken`, `sdo_oe`, `hold_active` and `lane3` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| hold_n | input | 1 | Pause pin (active low), or data lane 3 when quad_en is 1 |
| quad_en | input | 1 | Four-lane configuration bit |
| tx_en | input | 1 | Core asks for sdo to be driven |
| tx_byte | input | DATA_W | Next byte to shift out |
| tx_taken | output | 1 | One-cycle pulse when tx_byte has been loaded |
| rx_byte | output | DATA_W | Last byte received |
| rx_valid | output | 1 | One-cycle strobe for a new rx_byte |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; 0 means high impedance |
| hold_active | output | 1 | Pause in effect |
| lane3 | output | 1 | Pause pin level when in four-lane use |

## Verification
Bytes are sent with the clock idling low and with it idling high. This separates correct handling of a leading falling edge from that of a leading rising edge, and shows when the output byte is loaded. The pause is applied in four ways: with the clock low, with the clock high, in the middle of an input byte and in the middle of an output byte. These show whether entry and exit wait for a falling edge, and whether the frozen bit position resumes without losing or repeating a bit. A pause that is cut off by chip select distinguishes a real reset from a resumed partial byte. The same pause-pin activity with `quad_en` set shows that the pin then acts only as a lane and no longer pauses.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic sdi;
    logic hold_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, hold_n: 1'b1};
endpackage

// File: rtl/sflash_sync.sv
module sflash_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sflash_hold.sv
module sflash_hold (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic hold_en,
  input  logic sclk_lvl,
  input  logic hold_lvl,
  output logic held,
  output logic freeze
);
  logic enter_now;

  // Pause starts whenever the pin is low while the clock is low: immediately
  // if the clock is already low, else on the falling edge that lowers it.
  assign enter_now = hold_en & sel & ~sclk_lvl & ~hold_lvl & ~held;
  // The edge that starts or ends a pause is itself swallowed.
  assign freeze    = held | enter_now;

  always_ff @(posedge clk) begin
    if (rst || !sel || !hold_en) held <= 1'b0;
    else if (!sclk_lvl)          held <= ~hold_lvl;
  end
endmodule

// File: rtl/sflash_shift.sv
module sflash_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sel,
  input  logic         freeze,
  input  logic         rise,
  input  logic         fall,
  input  logic         sdi,
  input  logic [W-1:0] tx_byte,
  output logic [W-1:0] rx_byte,
  output logic         rx_valid,
  output logic         tx_taken,
  output logic         sdo
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;

  logic [CW-1:0] cnt;
  logic [W-1:0]  rx_sr;
  logic [W-1:0]  tx_sr;

  always_ff @(posedge clk) begin
    rx_valid <= 1'b0;
    tx_taken <= 1'b0;
    if (rst) begin
      cnt     <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rx_byte <= '0;
    end else if (!sel) begin
      cnt   <= '0;
      rx_sr <= '0;
      tx_sr <= '0;
    end else if (!freeze) begin
      if (rise) begin
        rx_sr <= {rx_sr[W-2:0], sdi};
        if (cnt == CW'(W-1)) begin
          cnt      <= '0;
          rx_byte  <= {rx_sr[W-2:0], sdi};
          rx_valid <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
      if (fall) begin
        if (cnt == '0) begin
          tx_sr    <= tx_byte;
          tx_taken <= 1'b1;
        end else begin
          tx_sr <= {tx_sr[W-2:0], 1'b0};
        end
      end
    end
  end

  assign sdo = tx_sr[W-1];
endmodule

// File: rtl/sflash_front.sv
module sflash_front #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              hold_n,
  input  logic              quad_en,
  input  logic              tx_en,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              tx_taken,
  output logic [DATA_W-1:0] rx_byte,
  output logic              rx_valid,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              hold_active,
  output logic              lane3
);
  import sflash_pkg::*;

  localparam int PW = $bits(pins_t);

  pins_t raw_pins, s_pins;
  logic  sclk_prev, rise, fall, sel, freeze;

  assign raw_pins = '{cs_n: cs_n, sclk: sclk, sdi: sdi, hold_n: hold_n};

  sflash_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PINS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(raw_pins), .q(s_pins)
  );

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= s_pins.sclk;
  end

  assign sel  = ~s_pins.cs_n;
  assign rise =  s_pins.sclk & ~sclk_prev;
  assign fall = ~s_pins.sclk &  sclk_prev;

  sflash_hold u_hold (
    .clk(clk), .rst(rst), .sel(sel), .hold_en(~quad_en),
    .sclk_lvl(s_pins.sclk), .hold_lvl(s_pins.hold_n),
    .held(hold_active), .freeze(freeze)
  );

  sflash_shift #(.W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .sel(sel), .freeze(freeze),
    .rise(rise), .fall(fall), .sdi(s_pins.sdi), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_taken(tx_taken), .sdo(sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_oe <= 1'b0;
      lane3  <= 1'b0;
    end else begin
      sdo_oe <= sel & tx_en & ~freeze;
      lane3  <= quad_en & s_pins.hold_n;
    end
  end
endmodule

// File: rtl/sflash_front_chk.sv
module sflash_front_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              quad_en,
  input logic              rx_valid,
  input logic              tx_taken,
  input logic [DATA_W-1:0] rx_byte,
  input logic              hold_active,
  input logic              sdo_oe
);
  p_strobe_single_r1: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  p_load_single_r2: assert property (@(posedge clk) disable iff (rst)
    tx_taken |=> !tx_taken);

  p_oe_off_in_pause_r3: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !sdo_oe);

  p_rx_frozen_r7: assert property (@(posedge clk) disable iff (rst)
    hold_active |=> $stable(rx_byte));

  p_no_strobe_in_pause_r7: assert property (@(posedge clk) disable iff (rst)
    hold_active |-> !rx_valid);

  p_quad_no_pause_r8: assert property (@(posedge clk) disable iff (rst)
    quad_en |=> !hold_active);
endmodule

bind sflash_front sflash_front_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .quad_en(quad_en), .rx_valid(rx_valid),
  .tx_taken(tx_taken), .rx_byte(rx_byte), .hold_active(hold_active),
  .sdo_oe(sdo_oe)
);

// File: tb/sflash_front_bench.sv
`timescale 1ns/1ps
module sflash_front_bench;
  localparam int H = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, hold_n = 1'b1;
  logic quad_en = 1'b0, tx_en = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_taken, rx_valid, sdo, sdo_oe, hold_active, lane3;
  logic [7:0] rx_byte;

  int checks = 0, errors = 0, nvalid = 0, ntaken = 0;
  logic [7:0] last_rx = 8'h00;

  always #2 clk = ~clk;

  sflash_front u_sflash_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .hold_n(hold_n), .quad_en(quad_en), .tx_en(tx_en), .tx_byte(tx_byte),
    .tx_taken(tx_taken), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .sdo(sdo), .sdo_oe(sdo_oe), .hold_active(hold_active), .lane3(lane3)
  );

  always @(negedge clk) begin
    if (rx_valid) begin last_rx = rx_byte; nvalid++; end
    if (tx_taken) ntaken++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // idle-low clock: bits [from..to] of v, MSB first, ends with clock low
  task automatic send_bits(input logic [7:0] v, input int from, input int to);
    for (int i = from; i <= to; i++) begin
      sdi = v[7-i]; step(H);
      sclk = 1'b1; step(H);
      sclk = 1'b0;
    end
    step(H);
  endtask

  task automatic t_reset;
    check(rx_valid == 0 && tx_taken == 0 && sdo_oe == 0 && hold_active == 0 && lane3 == 0,
          "R10 reset state", {rx_valid, tx_taken, sdo_oe, hold_active, lane3}, 0);
  endtask

  task automatic t_mode0;
    int n0;
    n0 = nvalid; tx_en = 1'b0;
    sclk = 1'b0; cs_n = 1'b0; step(H);
    check(sdo_oe == 0, "R3 oe off with tx_en low", sdo_oe, 0);
    send_bits(8'hA5, 0, 7);
    check(last_rx == 8'hA5 && nvalid == n0 + 1, "R1 idle-low byte 1", last_rx, 8'hA5);
    send_bits(8'h3C, 0, 7);
    check(last_rx == 8'h3C && nvalid == n0 + 2, "R1 idle-low byte 2", last_rx, 8'h3C);
    cs_n = 1'b1; step(H);
  endtask

  task automatic t_mode3_tx;
    logic [7:0] rxv;
    int n0, t0;
    rxv = 8'h96; n0 = nvalid; t0 = ntaken;
    tx_byte = 8'hC6; tx_en = 1'b1;
    sclk = 1'b1; step(H); cs_n = 1'b0; step(H);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; step(H);
      check(sdo == tx_byte[7-i], "R2 idle-high out bit", sdo, tx_byte[7-i]);
      if (i == 0) check(sdo_oe == 1, "R3 oe on when selected", sdo_oe, 1);
      sdi = rxv[7-i]; step(H);
      sclk = 1'b1; step(H);
    end
    check(last_rx == rxv && nvalid == n0 + 1, "R1 idle-high byte", last_rx, rxv);
    check(ntaken == t0 + 1, "R2 one load per byte", ntaken - t0, 1);
    cs_n = 1'b1; step(H);
    check(sdo_oe == 0, "R3 oe off when deselected", sdo_oe, 0);
    sclk = 1'b0; tx_en = 1'b0; step(H);
  endtask

  task automatic t_hold_low;
    int n0;
    n0 = nvalid; cs_n = 1'b0; step(H);
    send_bits(8'hA5, 0, 3);
    hold_n = 1'b0; step(5);
    check(hold_active == 1, "R4 immediate entry", hold_active, 1);
    for (int i = 0; i < 3; i++) begin
      sdi = 1'b1; step(H); sclk = 1'b1; step(H); sclk = 1'b0; step(H);
    end
    check(hold_active == 1 && nvalid == n0, "R7 clock ignored in pause", nvalid - n0, 0);
    hold_n = 1'b1; step(5);
    check(hold_active == 0, "R6 immediate exit", hold_active, 0);
    send_bits(8'hA5, 4, 7);
    check(last_rx == 8'hA5 && nvalid == n0 + 1, "R7 byte resumes", last_rx, 8'hA5);
    cs_n = 1'b1; step(H);
  endtask

  task automatic t_hold_high;
    int n0;
    n0 = nvalid; cs_n = 1'b0; step(H);
    send_bits(8'h5A, 0, 2);
    sdi = 1'b1; step(H); sclk = 1'b1; step(H);          // bit 3 of 0x5A is 1
    hold_n = 1'b0; step(H);
    check(hold_active == 0, "R5 no entry while clock high", hold_active, 1'b0);
    sclk = 1'b0; step(5);
    check(hold_active == 1, "R5 entry at falling edge", hold_active, 1);
    step(H); sclk = 1'b1; step(H);
    hold_n = 1'b1; step(H);
    check(hold_active == 1, "R6 no exit while clock high", hold_active, 1);
    sclk = 1'b0; step(5);
    check(hold_active == 0, "R6 exit at falling edge", hold_active, 0);
    step(H);
    send_bits(8'h5A, 4, 7);
    check(last_rx == 8'h5A && nvalid == n0 + 1, "R7 byte resumes after deferred pause", last_rx, 8'h5A);
    cs_n = 1'b1; step(H);
  endtask

  task automatic t_hold_tx;
    int t0;
    t0 = ntaken; tx_byte = 8'hB4; tx_en = 1'b1;
    sclk = 1'b1; step(H); cs_n = 1'b0; step(H);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; step(H);
      check(sdo == tx_byte[7-i], "R7 out bit across pause", sdo, tx_byte[7-i]);
      if (i == 3) begin
        hold_n = 1'b0; step(5);
        check(sdo_oe == 0, "R7 output released in pause", sdo_oe, 0);
        sclk = 1'b1; step(H); sclk = 1'b0; step(H);
        sclk = 1'b1; step(H); sclk = 1'b0; step(H);
        hold_n = 1'b1; step(5);
        check(sdo_oe == 1 && sdo == tx_byte[7-i], "R7 output resumes same bit", sdo, tx_byte[7-i]);
      end
      step(H); sclk = 1'b1; step(H);
    end
    check(ntaken == t0 + 1, "R7 no extra load", ntaken - t0, 1);
    cs_n = 1'b1; step(H); sclk = 1'b0; tx_en = 1'b0; step(H);
  endtask

  task automatic t_cs_in_hold;
    int n0;
    n0 = nvalid; cs_n = 1'b0; step(H);
    send_bits(8'hFF, 0, 2);
    hold_n = 1'b0; step(5);
    cs_n = 1'b1; step(6);
    check(hold_active == 0, "R9 deselect ends pause", hold_active, 0);
    hold_n = 1'b1; step(H); cs_n = 1'b0; step(H);
    send_bits(8'h5A, 0, 7);
    check(last_rx == 8'h5A && nvalid == n0 + 1, "R9 partial byte dropped", last_rx, 8'h5A);
    cs_n = 1'b1; step(H);
  endtask

  task automatic t_quad;
    int n0;
    n0 = nvalid; quad_en = 1'b1; cs_n = 1'b0; step(H);
    send_bits(8'hC3, 0, 3);
    hold_n = 1'b0; step(5);
    check(hold_active == 0 && lane3 == 0, "R8 no pause, lane low", {hold_active, lane3}, 0);
    send_bits(8'hC3, 4, 7);
    check(last_rx == 8'hC3 && nvalid == n0 + 1, "R8 bytes flow with pin low", last_rx, 8'hC3);
    hold_n = 1'b1; step(5);
    check(lane3 == 1, "R8 lane follows pin", lane3, 1);
    quad_en = 1'b0; step(5);
    check(lane3 == 0, "R8 lane zero when off", lane3, 0);
    cs_n = 1'b1; step(H);
  endtask

  initial begin
    step(4); rst = 1'b0; step(4);
    t_reset();
    t_mode0();
    t_mode3_tx();
    t_hold_low();
    t_hold_high();
    t_hold_tx();
    t_cs_in_hold();
    t_quad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule